// File: doc/BRIEF.md
# Interrupt-Flag Serial Port

This block is a byte-wide serial port that sits on the I/O bus of a small 8-bit processor. Four consecutive I/O addresses, starting at a base address set by a parameter, give access to it. One address is the data port. One is a status port. Two hold the low and high bytes of a 16-bit bit-period divisor. Writing the data port sends one asynchronous frame: a start bit, eight data bits with the least significant bit first, and one stop bit. Reading the data port returns the last byte that the receive side assembled.

Each direction has two status bits. The ready bit follows the state of the datapath. The interrupt flag is sticky: it latches the event that set it and holds until software writes a one to that bit position in the status port. A single interrupt request is raised while either flag is set, so one handler can serve both directions. The handler reads the status port to find the cause and acknowledges each cause separately.

The receiver resynchronises the serial input. It detects the falling edge of a start bit, confirms the start bit at its middle, and then samples every following bit one bit period later.

Top module: `sio_irq_uart`

## Requirements
- R1: After reset the status port reads 0x01 (only the transmit-ready bit set), the interrupt request is low, the serial output idles high, and the divisor reads back 7 (low byte 0x07, high byte 0x00).
- R2: The port offsets from the base address are: data at +0, status at +1, divisor low byte at +2, divisor high byte at +3. Both divisor bytes read back what was last written to them. Addresses outside the four-port window read 0x00.
- R3: Writing the data port while the transmitter is idle starts a frame on the serial output. The frame is a low start bit, the eight data bits with the LSB first, and a high stop bit. Each bit lasts divisor+1 clocks.
- R4: Status bit 0 (transmit ready) is 0 from the clock after an accepted data write until the frame ends. A data write made while a frame is in progress is ignored, so that frame completes unchanged and no second frame follows it.
- R5: At the end of the stop bit, status bit 4 (transmit interrupt flag) sets and transmit ready returns to 1.
- R6: The receiver samples a frame on the serial input at mid-bit and loads the eight data bits into the data register, which the data port returns. A later byte overwrites an unread one.
- R7: Status bit 1 (receive ready) sets when a byte is loaded and clears when the data port is read.
- R8: Status bit 5 (receive interrupt flag) sets when a byte is loaded. Reading the data port does not clear it.
- R9: Writing the status port with bit 5 set clears the receive flag, and writing it with bit 4 set clears the transmit flag. A zero in either position leaves that flag as it is, and all other status bits ignore writes.
- R10: The interrupt request is high exactly while at least one of the two interrupt flags is set.
- R11: A low pulse on the serial input that ends before the middle of the start bit does not produce a byte.
- R12: A frame whose stop bit samples low is dropped: no flag changes and the data register keeps its value. The receiver then accepts the next valid frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | I/O port address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port (combinational) |
| ser_rx | input | 1 | Serial receive line |
| ser_tx | output | 1 | Serial transmit line |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that every bus access is a single-cycle strobe and that read and write are never asserted in the same cycle. They also assume the divisor is only changed while both directions are idle. The bench drives each access for exactly one clock from the falling edge. It programs the divisor only between tests, and it holds each serial bit for a full bit period, except in the deliberate short-pulse and bad-stop-bit cases.

// File: rtl/sio_uart_pkg.sv
package sio_uart_pkg;

  localparam int BUS_W = 8;
  localparam int DIV_W = 2 * BUS_W;

  // port offsets inside the four-address window
  localparam logic [1:0] OFF_DATA = 2'd0;
  localparam logic [1:0] OFF_STAT = 2'd1;
  localparam logic [1:0] OFF_DIVL = 2'd2;
  localparam logic [1:0] OFF_DIVH = 2'd3;

  // status bit positions (software decodes these)
  localparam int ST_TX_RDY = 0;
  localparam int ST_RX_RDY = 1;
  localparam int ST_TX_IRQ = 4;
  localparam int ST_RX_IRQ = 5;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

  function automatic logic [BUS_W-1:0] pack_status(input logic tx_rdy, input logic rx_rdy,
                                                   input logic tx_irq, input logic rx_irq);
    logic [BUS_W-1:0] s;
    s = '0;
    s[ST_TX_RDY] = tx_rdy;
    s[ST_RX_RDY] = rx_rdy;
    s[ST_TX_IRQ] = tx_irq;
    s[ST_RX_IRQ] = rx_irq;
    return s;
  endfunction

  function automatic logic [DIV_W-1:0] join_div(input logic [BUS_W-1:0] hi,
                                                input logic [BUS_W-1:0] lo);
    return {hi, lo};
  endfunction

  // counter preload for the first tick after a start edge: half a bit period
  function automatic logic [DIV_W-1:0] half_period(input logic [DIV_W-1:0] div);
    return div >> 1;
  endfunction

endpackage

// File: rtl/sio_bit_timer.sv
module sio_bit_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_m1,
  input  logic             restart,
  input  logic             half,
  output logic             tick
);
  import sio_uart_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= half ? CNT_W'(half_period(DIV_W'(period_m1))) : period_m1;
    end else if (cnt_q == '0) begin
      cnt_q <= period_m1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = !restart && (cnt_q == '0);

endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  period_m1,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_LEN = DATA_W + 2;
  localparam int BCNT_W    = $clog2(FRAME_LEN);

  function automatic logic [FRAME_LEN-1:0] make_frame(input logic [DATA_W-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  logic [FRAME_LEN-1:0] shift_q;
  logic [BCNT_W-1:0]    bcnt_q;
  logic                 busy_q;
  logic                 go;
  logic                 tick;
  logic                 last_bit;

  assign go       = start && !busy_q;
  assign last_bit = (bcnt_q == BCNT_W'(FRAME_LEN - 1));

  sio_bit_timer #(.CNT_W(CNT_W)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_m1 (period_m1),
    .restart   (go),
    .half      (1'b0),
    .tick      (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '1;
      bcnt_q  <= '0;
      busy_q  <= 1'b0;
    end else if (go) begin
      shift_q <= make_frame(data);
      bcnt_q  <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q && tick) begin
      if (last_bit) begin
        busy_q <= 1'b0;
      end else begin
        shift_q <= {1'b1, shift_q[FRAME_LEN-1:1]};
        bcnt_q  <= bcnt_q + 1'b1;
      end
    end
  end

  assign txd  = busy_q ? shift_q[0] : 1'b1;
  assign busy = busy_q;
  assign done = busy_q && tick && last_bit;

endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  period_m1,
  input  logic              rxd,
  output logic [DATA_W-1:0] data,
  output logic              done
);
  import sio_uart_pkg::*;

  localparam int BCNT_W = $clog2(DATA_W);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line;
  logic                   line_prev_q;
  logic                   fall;
  rx_state_t              state_q;
  logic [DATA_W-1:0]      shift_q;
  logic [BCNT_W-1:0]      bcnt_q;
  logic                   tick;
  logic                   arm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q      <= '1;
      line_prev_q <= 1'b1;
    end else begin
      sync_q      <= {sync_q[SYNC_STAGES-2:0], rxd};
      line_prev_q <= line;
    end
  end

  assign line = sync_q[SYNC_STAGES-1];
  assign fall = line_prev_q && !line;
  assign arm  = (state_q == RX_IDLE) && fall;

  sio_bit_timer #(.CNT_W(CNT_W)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_m1 (period_m1),
    .restart   (arm),
    .half      (1'b1),
    .tick      (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      shift_q <= '0;
      bcnt_q  <= '0;
    end else begin
      case (state_q)
        RX_IDLE:  if (arm) state_q <= RX_START;
        RX_START: if (tick) begin
          state_q <= line ? RX_IDLE : RX_DATA;
          bcnt_q  <= '0;
        end
        RX_DATA:  if (tick) begin
          shift_q <= {line, shift_q[DATA_W-1:1]};
          if (bcnt_q == BCNT_W'(DATA_W - 1)) state_q <= RX_STOP;
          else bcnt_q <= bcnt_q + 1'b1;
        end
        RX_STOP:  if (tick) state_q <= RX_IDLE;
        default:  state_q <= RX_IDLE;
      endcase
    end
  end

  assign data = shift_q;
  assign done = (state_q == RX_STOP) && tick && line;

endmodule

// File: rtl/sio_irq_uart.sv
module sio_irq_uart #(
  parameter int          ADDR_W      = 8,
  parameter logic [7:0]  BASE_ADDR   = 8'h80,
  parameter logic [15:0] DIV_RESET   = 16'd7,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        ser_rx,
  output logic        ser_tx,
  output logic        irq
);
  import sio_uart_pkg::*;

  localparam int DATA_W = BUS_W;

  // register state
  logic [BUS_W-1:0]  div_lo_q, div_hi_q;
  logic [DATA_W-1:0] rx_data_q;
  logic              rx_rdy_q, rx_irq_q, tx_irq_q;

  // named events
  logic              hit;
  logic [1:0]        off;
  logic              wr_data, wr_stat, wr_divl, wr_divh, rd_data;
  logic              tx_busy, tx_ready, tx_done_w, rx_done_w, tx_go_w;
  logic [DATA_W-1:0] rx_byte;
  logic [DIV_W-1:0]  period_m1;

  assign hit     = (bus_addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
  assign off     = bus_addr[1:0];
  assign wr_data = bus_wr && hit && (off == OFF_DATA);
  assign wr_stat = bus_wr && hit && (off == OFF_STAT);
  assign wr_divl = bus_wr && hit && (off == OFF_DIVL);
  assign wr_divh = bus_wr && hit && (off == OFF_DIVH);
  assign rd_data = bus_rd && hit && (off == OFF_DATA);

  assign period_m1 = join_div(div_hi_q, div_lo_q);
  assign tx_ready  = !tx_busy;
  assign tx_go_w   = wr_data && tx_ready;

  sio_tx #(.DATA_W(DATA_W), .CNT_W(DIV_W)) tx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_m1 (period_m1),
    .start     (wr_data),
    .data      (bus_wdata),
    .txd       (ser_tx),
    .busy      (tx_busy),
    .done      (tx_done_w)
  );

  sio_rx #(.DATA_W(DATA_W), .CNT_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) rx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_m1 (period_m1),
    .rxd       (ser_rx),
    .data      (rx_byte),
    .done      (rx_done_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_lo_q <= DIV_RESET[7:0];
      div_hi_q <= DIV_RESET[15:8];
    end else begin
      if (wr_divl) div_lo_q <= bus_wdata;
      if (wr_divh) div_hi_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data_q <= '0;
      rx_rdy_q  <= 1'b0;
      rx_irq_q  <= 1'b0;
      tx_irq_q  <= 1'b0;
    end else begin
      if (rx_done_w) rx_data_q <= rx_byte;

      if (rx_done_w)    rx_rdy_q <= 1'b1;
      else if (rd_data) rx_rdy_q <= 1'b0;

      if (rx_done_w)                             rx_irq_q <= 1'b1;
      else if (wr_stat && bus_wdata[ST_RX_IRQ]) rx_irq_q <= 1'b0;

      if (tx_done_w)                             tx_irq_q <= 1'b1;
      else if (wr_stat && bus_wdata[ST_TX_IRQ]) tx_irq_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (off)
        OFF_DATA: bus_rdata = rx_data_q;
        OFF_STAT: bus_rdata = pack_status(tx_ready, rx_rdy_q, tx_irq_q, rx_irq_q);
        OFF_DIVL: bus_rdata = div_lo_q;
        default:  bus_rdata = div_hi_q;
      endcase
    end
  end

  assign irq = rx_irq_q || tx_irq_q;

endmodule

// File: rtl/sio_irq_uart_chk.sv
module sio_irq_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       ser_tx,
  input logic       tx_ready,
  input logic       rx_rdy_q,
  input logic       rx_irq_q,
  input logic       tx_irq_q,
  input logic       tx_done_w,
  input logic       rx_done_w,
  input logic       tx_go_w,
  input logic       wr_stat,
  input logic [7:0] bus_wdata
);

  // R3: an accepted write drives the start bit on the next cycle
  a_r3_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go_w |=> !ser_tx);

  // R4: transmitter leaves ready once a frame is accepted
  a_r4_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go_w |=> !tx_ready);

  // R5: end of frame raises the transmit flag and ready
  a_r5_tx_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_w |=> (tx_irq_q && tx_ready));

  // R7: a loaded byte sets receive ready and its flag
  a_r7_rx_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_w |=> (rx_rdy_q && rx_irq_q));

  // R8: the receive flag only drops on a write-one to bit 5
  a_r8_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq_q && !(wr_stat && bus_wdata[5])) |=> rx_irq_q);

  // R9: transmit flag only drops on a write-one to bit 4
  a_r9_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq_q && !(wr_stat && bus_wdata[4])) |=> tx_irq_q);

  // R10: request rises only after a completion event
  a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tx_done_w || rx_done_w));

  // R10: request falls only after a status write
  a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_stat));

endmodule

bind sio_irq_uart sio_irq_uart_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .ser_tx    (ser_tx),
  .tx_ready  (tx_ready),
  .rx_rdy_q  (rx_rdy_q),
  .rx_irq_q  (rx_irq_q),
  .tx_irq_q  (tx_irq_q),
  .tx_done_w (tx_done_w),
  .rx_done_w (rx_done_w),
  .tx_go_w   (tx_go_w),
  .wr_stat   (wr_stat),
  .bus_wdata (bus_wdata)
);

// File: tb/sio_irq_uart_tb_top.sv
module sio_irq_uart_tb_top;

  localparam logic [7:0] A_DATA = 8'h80;
  localparam logic [7:0] A_STAT = 8'h81;
  localparam logic [7:0] A_DIVL = 8'h82;
  localparam logic [7:0] A_DIVH = 8'h83;
  localparam int BITC = 8;   // divisor 7 -> 8 clocks per bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ser_rx;
  logic       ser_tx;
  logic       irq;
  logic       rx_drv = 1'b1;
  logic       loop = 1'b0;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign ser_rx = loop ? ser_tx : rx_drv;

  sio_irq_uart dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ser_rx    (ser_rx),
    .ser_tx    (ser_tx),
    .irq       (irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, int'(v), int'(exp));
  endtask

  function automatic logic frame_bit(input logic [7:0] b, input int i);
    if (i == 0) return 1'b0;
    if (i == 9) return 1'b1;
    return b[i-1];
  endfunction

  task automatic send_serial(input logic [7:0] b, input logic stop);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rx_drv = (i == 9) ? stop : frame_bit(b, i);
      repeat (BITC - 1) @(negedge clk);
    end
    @(negedge clk);
    rx_drv = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 ser_tx idle", int'(ser_tx), 1);
    expect_reg("R1 status after reset", A_STAT, 8'h01);
    expect_reg("R1 divisor low reset", A_DIVL, 8'h07);
    expect_reg("R1 divisor high reset", A_DIVH, 8'h00);
  endtask

  task automatic t_divisor();
    wr(A_DIVL, 8'h34);
    wr(A_DIVH, 8'h12);
    expect_reg("R2 divisor low readback", A_DIVL, 8'h34);
    expect_reg("R2 divisor high readback", A_DIVH, 8'h12);
    expect_reg("R2 unmapped above", 8'h84, 8'h00);
    expect_reg("R2 unmapped below", 8'h7F, 8'h00);
    wr(A_DIVL, 8'h07);
    wr(A_DIVH, 8'h00);
  endtask

  task automatic t_tx_frame(input logic [7:0] b);
    wr(A_DATA, b);
    bus_addr = A_STAT;
    repeat (3) @(negedge clk);        // middle of start bit
    for (int i = 0; i < 10; i++) begin
      chk($sformatf("R3 tx bit %0d of %02h", i, b), int'(ser_tx), int'(frame_bit(b, i)));
      if (i == 4) chk("R4 tx ready low mid-frame", int'(bus_rdata[0]), 0);
      repeat (BITC) @(negedge clk);
    end
    expect_reg("R5 status after frame", A_STAT, 8'h11);
    chk("R10 irq with tx flag", int'(irq), 1);
    wr(A_STAT, 8'h2E);
    expect_reg("R9 zero in bit4 keeps tx flag", A_STAT, 8'h11);
    wr(A_STAT, 8'h10);
    expect_reg("R9 one in bit4 clears tx flag", A_STAT, 8'h01);
    chk("R10 irq low with no flags", int'(irq), 0);
  endtask

  task automatic t_rx(input logic [7:0] b);
    send_serial(b, 1'b1);
    repeat (12) @(negedge clk);
    expect_reg("R7 status after rx", A_STAT, 8'h23);
    chk("R10 irq with rx flag", int'(irq), 1);
    expect_reg($sformatf("R6 rx data %02h", b), A_DATA, b);
    expect_reg("R8 flag kept, R7 ready cleared by read", A_STAT, 8'h21);
    wr(A_STAT, 8'h10);
    expect_reg("R9 bit4 write leaves rx flag", A_STAT, 8'h21);
    wr(A_STAT, 8'h20);
    expect_reg("R9 bit5 write clears rx flag", A_STAT, 8'h01);
    chk("R10 irq low after rx clear", int'(irq), 0);
  endtask

  task automatic t_overrun();
    send_serial(8'h01, 1'b1);
    repeat (4) @(negedge clk);
    send_serial(8'h80, 1'b1);
    repeat (12) @(negedge clk);
    expect_reg("R6 newer byte overwrites", A_DATA, 8'h80);
    wr(A_STAT, 8'h20);
    expect_reg("R7 status after overrun clear", A_STAT, 8'h01);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    rx_drv = 1'b0;
    repeat (2) @(negedge clk);
    rx_drv = 1'b1;
    repeat (12 * BITC) @(negedge clk);
    expect_reg("R11 short low pulse ignored", A_STAT, 8'h01);
    chk("R11 irq stays low", int'(irq), 0);
  endtask

  task automatic t_framing();
    logic [7:0] prev;
    rd(A_DATA, prev);
    send_serial(8'h55, 1'b0);   // stop bit low; line back high after it
    repeat (4 * BITC) @(negedge clk);
    expect_reg("R12 bad stop bit gives no flags", A_STAT, 8'h01);
    expect_reg("R12 data register unchanged", A_DATA, prev);
    t_rx(8'h5A);                // recovery
  endtask

  task automatic t_loop_busy();
    logic [7:0] v;
    bit got;
    loop = 1'b1;
    wr(A_DATA, 8'hC3);
    repeat (20) @(negedge clk);
    wr(A_DATA, 8'h3C);          // must be ignored
    got = 0;
    for (int n = 0; n < 200 && !got; n++) begin
      rd(A_STAT, v);
      if (v[1]) got = 1;
    end
    chk("R6 loopback byte arrived", int'(got), 1);
    expect_reg("R4 busy write ignored, first byte kept", A_DATA, 8'hC3);
    repeat (25 * BITC) @(negedge clk);
    expect_reg("R4 no second frame", A_STAT, 8'h31);
    wr(A_STAT, 8'h30);
    expect_reg("R9 both flags cleared together", A_STAT, 8'h01);
    chk("R10 irq low after both cleared", int'(irq), 0);
    loop = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_divisor();
    t_tx_frame(8'hA5);
    t_tx_frame(8'h01);
    t_rx(8'h3C);
    t_rx(8'hFF);
    t_overrun();
    t_glitch();
    t_framing();
    t_loop_busy();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule